// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block drives a raw NAND bus-cycle interface (command, address, data-out and data-in strobes, plus the ready/busy line) to carry out two vendor parameter operations. The first loads one read-retry mode into the die: it opens a parameter-write window, writes each internal retry register with the value stored for the chosen mode, and closes the window so the die applies the values. The second pulls the read-retry table out of the one-time-programmable area. It switches the die into that area, reads a page of a configured length and streams each byte out of a byte port. It then leaves the area by resetting the die, clearing the switch register and doing a dummy page read.

A host writes the per-mode register values into an internal table through a simple write port. It then pulses `start_i` with an operation select, a mode index and an OTP configuration select. The sequencer paces every bus cycle on ready/busy, gives up after a programmable stall time, and signals the end of each operation with a single-cycle `done_o`. `err_o` accompanies `done_o` when the operation was abandoned.

Top module: `nand_param_seq`

## Requirements
- R1: A retry-load operation (`op_otp_i`=0) issues a command cycle 0x36, then for each register r = 0..NREGS-1 an address cycle carrying the register offset followed by a data-out cycle carrying its value, then a command cycle 0x16, then completes. Bus kind codes on `bus_kind_o`: 0 command, 1 address, 2 data-out, 3 data-in.
- R2: For mode m the value sent for register r is table entry m*NREGS + r. The offsets are sent in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF by default.
- R3: An OTP fetch (`op_otp_i`=1) first issues commands 0xFF, 0x36, address 0x38, data-out 0x52, command 0x16, then commands 0x17, 0x04, 0x19. It then reads the page with command 0x00, two zero column address cycles, three row address cycles carrying the page number least significant byte first, command 0x30, and one data-in cycle per byte of the configured length (data-in cycles carry byte 0x00 on `bus_byte_o`).
- R4: `cfg_i`=0 selects page 0x21F with 784 bytes; `cfg_i`=1 selects page 0x200 with 528 bytes.
- R5: After the OTP bytes, the fetch issues commands 0xFF, 0x36, address 0x38, data-out 0x00, command 0x16, then command 0x00, five zero address cycles and command 0x30, with no data-in cycle. It completes when ready/busy is high again.
- R6: Each data-in byte appears on `otp_byte_o` with `otp_vld_o` high in the cycle after its strobe, with `otp_idx_o` counting 0, 1, 2 ... within the fetch.
- R7: A bus cycle is issued only when `nand_rb_i` was high at the issuing edge, and at least one cycle without a strobe separates two bus cycles.
- R8: If `nand_rb_i` stays low for TMO_CYCLES consecutive issue opportunities, the operation ends with `done_o` and `err_o` high for one cycle and the block returns to idle, ready for a new start.
- R9: `done_o` is a one-cycle pulse, raised once per accepted start; `err_o` is only high together with `done_o`; a start pulse while `busy_o` is high is ignored.
- R10: After reset no strobe, done, error or stream output is active and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_otp_i | input | 1 | 0 = load retry mode, 1 = fetch OTP table |
| mode_i | input | MODE_W | Retry mode index |
| cfg_i | input | 1 | OTP page/length configuration select |
| tbl_we_i | input | 1 | Value table write enable |
| tbl_addr_i | input | TBL_AW | Value table write address (m*NREGS + r) |
| tbl_data_i | input | 8 | Value table write data |
| nand_rb_i | input | 1 | Ready/busy, high when ready |
| nand_din_i | input | 8 | Read data, sampled at the end of a data-in strobe |
| bus_vld_o | output | 1 | One-cycle bus cycle strobe |
| bus_kind_o | output | 2 | Bus cycle kind (0 cmd, 1 addr, 2 data-out, 3 data-in) |
| bus_byte_o | output | 8 | Command, address or data byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| otp_vld_o | output | 1 | OTP byte valid |
| otp_byte_o | output | 8 | OTP byte |
| otp_idx_o | output | LEN_W | OTP byte index |

## Verification
The assertions watch, every cycle, the bus pacing: the idle cycle after each strobe, issue only after ready, the single-cycle done with error only beside it, the return to idle at done, busy rising only from a start, and stream bytes that follow a data-in strobe. Only the bench scenarios can show that the bytes and kinds form the right command scripts in the right order. They also show that table indexing by mode picks the right values, that both OTP configurations choose their page and length, and that a stalled ready line ends the fetch at the expected time with recovery afterwards. The same scenarios show that a second start during an operation leaves the bus script untouched.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DOUT = 2'd2,
    K_DIN  = 2'd3
  } bus_kind_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RESET, PH_SET, PH_RADDR, PH_RDAT, PH_OADDR, PH_ODAT,
    PH_APPLY, PH_E17, PH_E04, PH_E19, PH_PCMD, PH_PADDR, PH_PCONF,
    PH_PDATA, PH_FIN
  } phase_e;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_PARAM   = 8'h36;
  localparam logic [7:0] OP_COMMIT  = 8'h16;
  localparam logic [7:0] OP_OTP_A   = 8'h17;
  localparam logic [7:0] OP_OTP_B   = 8'h04;
  localparam logic [7:0] OP_OTP_C   = 8'h19;
  localparam logic [7:0] OP_READ1   = 8'h00;
  localparam logic [7:0] OP_READ2   = 8'h30;
  localparam logic [7:0] OTP_SW_REG = 8'h38;
  localparam logic [7:0] OTP_SW_ON  = 8'h52;
  localparam logic [7:0] OTP_SW_OFF = 8'h00;

endpackage

// File: rtl/nps_value_ram.sv
module nps_value_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nps_stall_timer.sv
module nps_stall_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic stall,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q;

  assign expired = stall && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !stall || expired) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nps_otp_capture.sv
module nps_otp_capture #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       din,
  output logic             vld,
  output logic [7:0]       byte_o,
  output logic [LEN_W-1:0] idx
);
  logic [LEN_W-1:0] next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      byte_o <= '0;
      idx    <= '0;
      next_q <= '0;
    end else begin
      vld <= take;
      if (clr) begin
        next_q <= '0;
      end else if (take) begin
        byte_o <= din;
        idx    <= next_q;
        next_q <= next_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_param_seq.sv
module nand_param_seq
  import nps_pkg::*;
#(
  parameter int               NREGS      = 8,
  parameter int               NMODES     = 8,
  parameter logic [NREGS*8-1:0] REG_LIST = 64'hAF_AE_AD_CD_AB_AA_BF_CC,
  parameter int               PAGE_W     = 24,
  parameter int               COL_CYC    = 2,
  parameter int               ROW_CYC    = 3,
  parameter logic [23:0]      OTP_PAGE_A = 24'h00021F,
  parameter int               OTP_LEN_A  = 784,
  parameter logic [23:0]      OTP_PAGE_B = 24'h000200,
  parameter int               OTP_LEN_B  = 528,
  parameter int               TMO_CYCLES = 1024,
  localparam int MODE_W    = (NMODES > 1) ? $clog2(NMODES) : 1,
  localparam int TBL_DEPTH = NMODES * NREGS,
  localparam int TBL_AW    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int MAXLEN    = (OTP_LEN_A > OTP_LEN_B) ? OTP_LEN_A : OTP_LEN_B,
  localparam int LEN_W     = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_otp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cfg_i,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [7:0]        tbl_data_i,
  input  logic              nand_rb_i,
  input  logic [7:0]        nand_din_i,
  output logic              bus_vld_o,
  output logic [1:0]        bus_kind_o,
  output logic [7:0]        bus_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              otp_vld_o,
  output logic [7:0]        otp_byte_o,
  output logic [LEN_W-1:0]  otp_idx_o
);
  localparam int REG_W    = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int ADDR_CYC = COL_CYC + ROW_CYC;

  phase_e              phase_q, nphase;
  logic                gap_q, op_q, exit_q;
  logic [MODE_W-1:0]   mode_q;
  logic [REG_W-1:0]    reg_idx_q;
  logic [LEN_W-1:0]    cnt_q, len_q;
  logic [PAGE_W-1:0]   page_q;
  logic [7:0]          ram_q, addr_byte, s_byte;
  bus_kind_e           s_kind;
  logic                s_vld, reg_inc, reg_clr, cnt_inc, cnt_clr, set_exit;
  logic                stall, tmo, accept;
  logic [TBL_AW-1:0]   rd_addr;

  assign busy_o = (phase_q != PH_IDLE);
  assign accept = (phase_q == PH_IDLE) && start_i;
  assign stall  = busy_o && !gap_q && !nand_rb_i;
  assign rd_addr = TBL_AW'(int'(mode_q) * NREGS + int'(reg_idx_q));

  nps_value_ram #(.DEPTH(TBL_DEPTH), .AW(TBL_AW)) u_tbl (
    .clk(clk), .we(tbl_we_i), .waddr(tbl_addr_i), .wdata(tbl_data_i),
    .raddr(rd_addr), .rdata(ram_q)
  );

  nps_stall_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .stall(stall), .expired(tmo)
  );

  nps_otp_capture #(.LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst(rst), .clr(accept),
    .take(bus_vld_o && (bus_kind_o == K_DIN)),
    .din(nand_din_i), .vld(otp_vld_o), .byte_o(otp_byte_o), .idx(otp_idx_o)
  );

  // Address byte for page-read cycle cnt_q: columns are zero, rows LSB first
  always_comb begin
    if (int'(cnt_q) < COL_CYC) addr_byte = 8'h00;
    else addr_byte = 8'(page_q >> (8 * (int'(cnt_q) - COL_CYC)));
  end

  // Step decoder: what the current phase issues and where it goes next
  always_comb begin
    s_vld    = 1'b1;
    s_kind   = K_CMD;
    s_byte   = 8'h00;
    nphase   = phase_q;
    reg_inc  = 1'b0;
    reg_clr  = 1'b0;
    cnt_inc  = 1'b0;
    cnt_clr  = 1'b0;
    set_exit = 1'b0;
    unique case (phase_q)
      PH_RESET: begin s_byte = OP_RESET; nphase = PH_SET; end
      PH_SET: begin
        s_byte = OP_PARAM;
        nphase = op_q ? PH_OADDR : PH_RADDR;
      end
      PH_RADDR: begin
        s_kind = K_ADDR;
        s_byte = REG_LIST[8*reg_idx_q +: 8];
        nphase = PH_RDAT;
      end
      PH_RDAT: begin
        s_kind = K_DOUT;
        s_byte = ram_q;
        if (reg_idx_q == REG_W'(NREGS - 1)) begin
          nphase = PH_APPLY; reg_clr = 1'b1;
        end else begin
          nphase = PH_RADDR; reg_inc = 1'b1;
        end
      end
      PH_OADDR: begin s_kind = K_ADDR; s_byte = OTP_SW_REG; nphase = PH_ODAT; end
      PH_ODAT: begin
        s_kind = K_DOUT;
        s_byte = exit_q ? OTP_SW_OFF : OTP_SW_ON;
        nphase = PH_APPLY;
      end
      PH_APPLY: begin
        s_byte = OP_COMMIT;
        if (!op_q)       nphase = PH_FIN;
        else if (exit_q) nphase = PH_PCMD;
        else             nphase = PH_E17;
      end
      PH_E17: begin s_byte = OP_OTP_A; nphase = PH_E04; end
      PH_E04: begin s_byte = OP_OTP_B; nphase = PH_E19; end
      PH_E19: begin s_byte = OP_OTP_C; nphase = PH_PCMD; end
      PH_PCMD: begin s_byte = OP_READ1; nphase = PH_PADDR; cnt_clr = 1'b1; end
      PH_PADDR: begin
        s_kind = K_ADDR;
        s_byte = addr_byte;
        if (cnt_q == LEN_W'(ADDR_CYC - 1)) begin
          nphase = PH_PCONF; cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_PCONF: begin
        s_byte = OP_READ2;
        nphase = exit_q ? PH_FIN : PH_PDATA;
      end
      PH_PDATA: begin
        s_kind = K_DIN;
        if (cnt_q == len_q - 1'b1) begin
          nphase = PH_RESET; cnt_clr = 1'b1; set_exit = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_FIN: begin s_vld = 1'b0; nphase = PH_IDLE; end
      default: begin s_vld = 1'b0; nphase = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      gap_q      <= 1'b0;
      op_q       <= 1'b0;
      exit_q     <= 1'b0;
      mode_q     <= '0;
      reg_idx_q  <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
      page_q     <= '0;
      bus_vld_o  <= 1'b0;
      bus_kind_o <= K_CMD;
      bus_byte_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      bus_vld_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          op_q      <= op_otp_i;
          mode_q    <= mode_i;
          exit_q    <= 1'b0;
          gap_q     <= 1'b0;
          reg_idx_q <= '0;
          cnt_q     <= '0;
          page_q    <= PAGE_W'(cfg_i ? OTP_PAGE_B : OTP_PAGE_A);
          len_q     <= LEN_W'(cfg_i ? OTP_LEN_B : OTP_LEN_A);
          phase_q   <= op_otp_i ? PH_RESET : PH_SET;
        end
      end else if (gap_q) begin
        gap_q <= 1'b0;
      end else if (tmo) begin
        phase_q <= PH_IDLE;
        done_o  <= 1'b1;
        err_o   <= 1'b1;
      end else if (nand_rb_i) begin
        gap_q      <= 1'b1;
        phase_q    <= nphase;
        bus_vld_o  <= s_vld;
        bus_kind_o <= s_kind;
        bus_byte_o <= s_byte;
        if (reg_clr)      reg_idx_q <= '0;
        else if (reg_inc) reg_idx_q <= reg_idx_q + 1'b1;
        if (cnt_clr)      cnt_q <= '0;
        else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
        if (set_exit) begin
          exit_q <= 1'b1;
          page_q <= '0;
        end
        if (nphase == PH_IDLE) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nps_checker.sv
module nps_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       nand_rb_i,
  input logic       bus_vld_o,
  input logic [1:0] bus_kind_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       otp_vld_o
);
  assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (rst)
    bus_vld_o |=> !bus_vld_o);

  assert_issue_ready_R7: assert property (@(posedge clk) disable iff (rst)
    bus_vld_o |-> $past(nand_rb_i));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  assert_stream_follows_R6: assert property (@(posedge clk) disable iff (rst)
    otp_vld_o |-> $past(bus_vld_o && (bus_kind_o == 2'd3)));
endmodule

bind nand_param_seq nps_checker u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .nand_rb_i(nand_rb_i),
  .bus_vld_o(bus_vld_o), .bus_kind_o(bus_kind_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .otp_vld_o(otp_vld_o)
);

// File: tb/nand_param_seq_bench.sv
module nand_param_seq_bench;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_otp = 1'b0, cfg = 1'b0;
  logic [2:0] mode = '0;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic rb = 1'b1;
  logic [7:0] din = '0;
  logic bus_vld, busy, done, err, otp_vld;
  logic [1:0] bus_kind;
  logic [7:0] bus_byte, otp_byte;
  logic [9:0] otp_idx;

  always #4 clk = ~clk;

  nand_param_seq #(.TMO_CYCLES(TMO)) u_nand_param_seq (
    .clk(clk), .rst(rst), .start_i(start), .op_otp_i(op_otp), .mode_i(mode),
    .cfg_i(cfg), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .nand_rb_i(rb), .nand_din_i(din), .bus_vld_o(bus_vld), .bus_kind_o(bus_kind),
    .bus_byte_o(bus_byte), .busy_o(busy), .done_o(done), .err_o(err),
    .otp_vld_o(otp_vld), .otp_byte_o(otp_byte), .otp_idx_o(otp_idx)
  );

  int checks = 0, fails = 0, cyc = 0;
  int log_k [2000];
  int log_b [2000];
  int exp_k [2000];
  int exp_b [2000];
  int log_n = 0, exp_n = 0;
  int tbl [64];
  int busy_cnt = 0, rd_n = 0, ocnt = 0, otp_bad = 0, gap_bad = 0, rb_bad = 0;
  int done_n = 0, last_err = 0;
  bit stuck = 0, prev_vld = 0;

  function automatic logic [7:0] reg_of(int r);
    case (r)
      0: return 8'hCC; 1: return 8'hBF; 2: return 8'hAA; 3: return 8'hAB;
      4: return 8'hCD; 5: return 8'hAD; 6: return 8'hAE; default: return 8'hAF;
    endcase
  endfunction

  function automatic logic [7:0] otp_data(int i);
    return 8'((i * 7) ^ (i >> 3) ^ 8'h5A);
  endfunction

  // NAND model and monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (bus_vld) begin
      if (prev_vld) gap_bad++;
      if (!rb) rb_bad++;
      log_k[log_n] = int'(bus_kind);
      log_b[log_n] = int'(bus_byte);
      if (log_n < 1999) log_n++;
      if (bus_kind == 2'd0 && (bus_byte == 8'hFF || bus_byte == 8'h16 || bus_byte == 8'h30))
        busy_cnt = (stuck && bus_byte == 8'hFF) ? 1000000 : 1 + int'($urandom % 6);
      if (bus_kind == 2'd3) begin
        din = otp_data(rd_n);
        rd_n++;
      end
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
    if (!stuck && busy_cnt > 100) busy_cnt = 0;
    rb = (busy_cnt == 0);
    prev_vld = bus_vld;
    if (otp_vld) begin
      if (otp_byte != otp_data(ocnt) || int'(otp_idx) != ocnt) otp_bad++;
      ocnt++;
    end
    if (done) begin
      done_n++;
      last_err = int'(err);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic ep(int k, int b);
    exp_k[exp_n] = k;
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_apply(int m);
    exp_n = 0;
    ep(0, 'h36);
    for (int r = 0; r < 8; r++) begin
      ep(1, int'(reg_of(r)));
      ep(2, tbl[m * 8 + r]);
    end
    ep(0, 'h16);
  endtask

  task automatic build_otp(int c);
    int page = (c != 0) ? 'h200 : 'h21F;
    int len  = (c != 0) ? 528 : 784;
    exp_n = 0;
    ep(0, 'hFF); ep(0, 'h36); ep(1, 'h38); ep(2, 'h52); ep(0, 'h16);
    ep(0, 'h17); ep(0, 'h04); ep(0, 'h19);
    ep(0, 'h00); ep(1, 0); ep(1, 0);
    ep(1, page & 'hFF); ep(1, (page >> 8) & 'hFF); ep(1, (page >> 16) & 'hFF);
    ep(0, 'h30);
    for (int i = 0; i < len; i++) ep(3, 0);
    ep(0, 'hFF); ep(0, 'h36); ep(1, 'h38); ep(2, 'h00); ep(0, 'h16);
    ep(0, 'h00);
    for (int i = 0; i < 5; i++) ep(1, 0);
    ep(0, 'h30);
  endtask

  task automatic cmp_seq(string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_k[i] != exp_k[i] || log_b[i] != exp_b[i])) bad = i;
    if (log_n != exp_n && bad < 0) bad = (log_n < exp_n) ? log_n : exp_n;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s bus script at cycle %0d: actual kind %0d byte %0h expected kind %0d byte %0h (count %0d vs %0d)",
               tag, bad, log_k[bad], log_b[bad], exp_k[bad], exp_b[bad], log_n, exp_n);
    end
  endtask

  int elapsed;
  task automatic run_op(bit otp, int m, bit c, bit poke);
    int d0 = done_n;
    int t0 = cyc;
    log_n = 0; rd_n = 0; ocnt = 0; otp_bad = 0; gap_bad = 0; rb_bad = 0;
    @(negedge clk);
    op_otp = otp; mode = 3'(m); cfg = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      op_otp = ~otp; cfg = ~c; mode = 3'(m + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_n == d0) @(negedge clk);
    elapsed = cyc - t0;
    repeat (4) @(negedge clk);
    chk(done_n == d0 + 1, "R9", "done pulses per start", done_n - d0, 1);
  endtask

  task automatic fill_table();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl[i] = int'($urandom % 256);
      tbl_we = 1'b1; tbl_addr = 6'(i); tbl_data = 8'(tbl[i]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_apply(int m, string tag);
    build_apply(m);
    run_op(1'b0, m, 1'b0, 1'b0);
    cmp_seq(tag);
    chk(last_err == 0, tag, "error flag", last_err, 0);
    chk(gap_bad == 0 && rb_bad == 0, "R7", "pacing violations", gap_bad + rb_bad, 0);
  endtask

  task automatic do_otp(bit c);
    int len = c ? 528 : 784;
    build_otp(int'(c));
    run_op(1'b1, 0, c, 1'b0);
    cmp_seq(c ? "R4/cfg1 R3 R5" : "R3 R4/cfg0 R5");
    chk(ocnt == len, "R6", "stream byte count", ocnt, len);
    chk(otp_bad == 0, "R6", "stream byte/index mismatches", otp_bad, 0);
    chk(last_err == 0, "R5", "error flag", last_err, 0);
    chk(gap_bad == 0 && rb_bad == 0, "R7", "pacing violations", gap_bad + rb_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(!bus_vld && !done && !err && !otp_vld && !busy, "R10", "outputs in reset",
        int'({bus_vld, done, err, otp_vld, busy}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_vld && !busy && !done, "R10", "idle after reset", int'({bus_vld, busy, done}), 0);

    fill_table();
    do_apply(0, "R1 R2 mode0");
    do_apply(7, "R2 mode7");
    for (int k = 0; k < 6; k++) do_apply(int'($urandom % 8), "R1 R2 random");
    fill_table();
    do_apply(int'($urandom % 8), "R2 new table");

    do_otp(1'b0);
    do_otp(1'b1);

    // R9: start while busy is ignored
    build_apply(5);
    run_op(1'b0, 5, 1'b0, 1'b1);
    cmp_seq("R9 ignored start");

    // R8: stalled ready line ends the fetch with error
    stuck = 1'b1;
    exp_n = 0;
    ep(0, 'hFF);
    run_op(1'b1, 0, 1'b0, 1'b0);
    chk(last_err == 1, "R8", "error flag on timeout", last_err, 1);
    chk(elapsed >= TMO && elapsed <= TMO + 12, "R8", "cycles to timeout", elapsed, TMO + 3);
    cmp_seq("R8 only reset issued");
    chk(!busy, "R8", "idle after timeout", int'(busy), 0);
    stuck = 1'b0;
    repeat (3) @(negedge clk);
    do_apply(3, "R8 recovery R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule